// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block starts a DRAM after power-up and then keeps its contents alive. When reset is released it first holds every strobe inactive for a programmable start-up pause. It then runs a fixed number of back-to-back CAS-before-RAS (CBR) refresh cycles on its own. These cycles need no grant, because host traffic is still locked out at that point. When the last of them has finished, it raises the init-done flag.

From then on, an interval timer adds one owed refresh per period to a saturating counter. While anything is owed and the sequencer is idle, the block raises a request. When the access controller grants that request, the block drives one CBR strobe sequence: CAS falls first, RAS falls, CAS rises while RAS is still low, and RAS then precharges. WE stays high throughout. The counter drops by one per completed cycle, so grants that come late are made up by back-to-back cycles.

All timing values are given as clock-cycle counts in parameters. Strobe outputs are active low. They are meant to be multiplexed onto the DRAM pins by the access controller whenever `busy_o` is high.

Top module: `rfsh_sched`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `refresh_req_o`, `busy_o` and `init_done_o` are 0. This holds even when reset is asserted in the middle of a refresh cycle.
- R2: For the first PAUSE_CYC clock edges after reset release, RAS and CAS stay high. CAS falls at edge PAUSE_CYC+1.
- R3: Exactly INIT_CNT CBR cycles run after the pause, whatever the value of `grant_i`. `init_done_o` rises at edge PAUSE_CYC + INIT_CNT*(1+T_CSR+T_RAS+T_RP) after release and then stays high.
- R4: `refresh_req_o` is never 1 while `init_done_o` is 0.
- R5: In every refresh cycle, CAS falls while RAS is high and is low T_CSR cycles before RAS falls. CAS stays low for T_CSR+T_CHR cycles in total, then rises while RAS is still low.
- R6: `we_n_o` is 1 at every RAS fall, so no refresh cycle can be decoded as a write.
- R7: RAS stays low for exactly T_RAS cycles per refresh. Between two refresh cycles, RAS stays high for at least T_RP+T_CSR cycles.
- R8: Once `init_done_o` is high, one refresh is owed every INTERVAL_CYC cycles. With no grant, the first request appears INTERVAL_CYC cycles after `init_done_o` rises.
- R9: The owed count saturates at MAX_OWED. After W intervals without a grant, a held grant produces min(W, MAX_OWED) refresh cycles, after which the request falls.
- R10: When `refresh_req_o` and `grant_i` are both 1 at a clock edge, `busy_o` is 1 after that edge. `refresh_req_o` is 0 while `busy_o` is 1.
- R11: `grant_i` has no effect while `refresh_req_o` is 0: RAS stays high and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Access controller grants the pending refresh |
| ras_n_o | output | 1 | Row strobe request, active low |
| cas_n_o | output | 1 | Column strobe request, active low |
| we_n_o | output | 1 | Write enable request, active low (held high) |
| refresh_req_o | output | 1 | At least one refresh owed and sequencer idle |
| busy_o | output | 1 | Refresh strobe sequence in progress |
| init_done_o | output | 1 | Pause and initialization cycles complete |

## Verification
A phase register stuck in the wrong state shows up on the first cycle after reset release. Stray strobes during the pause, or `init_done_o` rising earlier or later than the exact edge count, give it away. A wrong owed count becomes visible on the next drain: the number of RAS falls under a held grant differs from min(W, MAX_OWED), or the request lingers or drops early. A sequencer state that is skipped or extended changes the RAS low width or the CAS-to-RAS ordering. That is caught at the very next RAS edge.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CSR,   // CAS low, RAS high
    SQ_RLO,   // both low
    SQ_RHLD,  // RAS low, CAS released
    SQ_PRE    // both high, precharge
  } sq_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAX_OWED = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic owed_o
);
  localparam int CW = $clog2(MAX_OWED + 1);
  localparam logic [CW-1:0] TOP = CW'(MAX_OWED);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != TOP)
      cnt_q <= cnt_q + CW'(1);
    else if (dec_i && !inc_i && cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign owed_o = (cnt_q != '0);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int T_HLD = T_RAS - T_CHR;
  localparam int M1    = (T_CSR > T_CHR) ? T_CSR : T_CHR;
  localparam int M2    = (T_HLD > T_RP) ? T_HLD : T_RP;
  localparam int MAXT  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(MAXT + 1);

  sq_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q  <= SQ_CSR;
          cnt_q <= CW'(T_CSR - 1);
        end
        SQ_CSR: if (last) begin
          st_q  <= SQ_RLO;
          cnt_q <= CW'(T_CHR - 1);
        end else cnt_q <= cnt_q - CW'(1);
        SQ_RLO: if (last) begin
          st_q  <= SQ_RHLD;
          cnt_q <= CW'(T_HLD - 1);
        end else cnt_q <= cnt_q - CW'(1);
        SQ_RHLD: if (last) begin
          st_q  <= SQ_PRE;
          cnt_q <= CW'(T_RP - 1);
        end else cnt_q <= cnt_q - CW'(1);
        SQ_PRE: if (last) begin
          st_q  <= SQ_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q - CW'(1);
        default: begin
          st_q  <= SQ_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign ras_n_o = !(st_q == SQ_RLO || st_q == SQ_RHLD);
  assign cas_n_o = !(st_q == SQ_CSR || st_q == SQ_RLO);
  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = (st_q == SQ_PRE) && last;
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_OWED     = 8,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 1,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic refresh_req_o,
  output logic busy_o,
  output logic init_done_o
);
  localparam int IW = $clog2(INIT_CNT + 1);
  localparam logic [IW-1:0] I_LAST = IW'(INIT_CNT - 1);

  phase_e        ph_q;
  logic [IW-1:0] icnt_q;
  logic          pause_tick, intv_tick;
  logic          seq_start, seq_busy, seq_done;
  logic          owed, req;

  rfsh_timer #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ph_q == PH_PAUSE),
    .tick_o (pause_tick)
  );

  rfsh_timer #(.PERIOD(INTERVAL_CYC)) u_intv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ph_q == PH_RUN),
    .tick_o (intv_tick)
  );

  // only run-phase completions pay back owed refreshes
  rfsh_backlog #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (intv_tick),
    .dec_i  (seq_done && ph_q == PH_RUN),
    .owed_o (owed)
  );

  rfsh_seq #(
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seq_start),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .busy_o  (seq_busy),
    .done_o  (seq_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_PAUSE;
      icnt_q <= '0;
    end else begin
      case (ph_q)
        PH_PAUSE: if (pause_tick) ph_q <= PH_INIT;
        PH_INIT: if (seq_done) begin
          if (icnt_q == I_LAST) ph_q <= PH_RUN;
          else                  icnt_q <= icnt_q + IW'(1);
        end
        PH_RUN:  ph_q <= PH_RUN;
        default: ph_q <= PH_PAUSE;
      endcase
    end
  end

  assign req       = (ph_q == PH_RUN) && owed && !seq_busy;
  assign seq_start = ((ph_q == PH_INIT) && !seq_busy) || (req && grant_i);

  assign we_n_o        = 1'b1;
  assign refresh_req_o = req;
  assign busy_o        = seq_busy;
  assign init_done_o   = (ph_q == PH_RUN);
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic refresh_req_o,
  input logic busy_o,
  input logic init_done_o
);
  // R4
  req_after_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !refresh_req_o);

  // R3
  init_done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  // R5
  cas_before_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && !$past(cas_n_o)));

  // R5
  cas_rise_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> !ras_n_o);

  // R10
  grant_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_req_o && grant_i) |=> busy_o);

  // R10
  no_req_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !refresh_req_o);

  // R11
  idle_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_n_o && cas_n_o));
endmodule

bind rfsh_sched rfsh_sched_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .grant_i       (grant_i),
  .ras_n_o       (ras_n_o),
  .cas_n_o       (cas_n_o),
  .refresh_req_o (refresh_req_o),
  .busy_o        (busy_o),
  .init_done_o   (init_done_o)
);

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
  localparam int CLK_P = 10;
  localparam int PAUSE = 20;
  localparam int NINIT = 8;
  localparam int INTV  = 40;
  localparam int MAXO  = 3;
  localparam int TCSR  = 1;
  localparam int TCHR  = 1;
  localparam int TRAS  = 5;
  localparam int TRP   = 3;
  localparam int CYC   = 1 + TCSR + TRAS + TRP;

  // intervals without grant -> expected refresh cycles on drain
  localparam int N_VEC = 4;
  localparam int WAIT_TBL [N_VEC] = '{1, 2, 3, 5};
  localparam int EXP_TBL  [N_VEC] = '{1, 2, 3, 3};

  logic clk = 1'b0;
  logic rst_ni, grant;
  logic ras_n, cas_n, we_n, req, busy, init_done;

  int total = 0;
  int bad = 0;
  int ras_falls = 0;
  bit finished = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  rfsh_sched #(
    .PAUSE_CYC    (PAUSE),
    .INIT_CNT     (NINIT),
    .INTERVAL_CYC (INTV),
    .MAX_OWED     (MAXO),
    .T_CSR        (TCSR),
    .T_CHR        (TCHR),
    .T_RAS        (TRAS),
    .T_RP         (TRP)
  ) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .grant_i       (grant),
    .ras_n_o       (ras_n),
    .cas_n_o       (cas_n),
    .we_n_o        (we_n),
    .refresh_req_o (req),
    .busy_o        (busy),
    .init_done_o   (init_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe timing monitor
  bit prev_ras = 1'b1, prev_cas = 1'b1, had_rise = 1'b0;
  int low_run = 0, high_run = 0, cas_run = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_ras = 1'b1; prev_cas = 1'b1; had_rise = 1'b0;
      low_run = 0; high_run = 0; cas_run = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        ras_falls++;
        chk(!cas_n && !prev_cas, "R5 CAS low before RAS fall", int'(prev_cas), 0);
        chk(we_n == 1'b1, "R6 WE high at RAS fall", int'(we_n), 1);
        if (had_rise)
          chk(high_run >= TRP + TCSR, "R7 RAS high between cycles", high_run, TRP + TCSR);
        low_run = 1;
      end else if (!ras_n) low_run++;
      if (!prev_ras && ras_n) begin
        chk(low_run == TRAS, "R7 RAS low width", low_run, TRAS);
        had_rise = 1'b1;
        high_run = 1;
      end else if (ras_n) high_run++;
      if (prev_cas && !cas_n) begin
        chk(ras_n == 1'b1, "R5 CAS falls with RAS high", int'(ras_n), 1);
        cas_run = 1;
      end else if (!cas_n) cas_run++;
      if (!prev_cas && cas_n) begin
        chk(cas_run == TCSR + TCHR, "R5 CAS low width", cas_run, TCSR + TCHR);
        chk(ras_n == 1'b0, "R5 CAS rises while RAS low", int'(ras_n), 0);
      end
      if (!init_done && req) chk(1'b0, "R4 request before init done", 1, 0);
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit quiet;
    int base;
    rst_ni = 1'b0;
    grant  = 1'b1;  // held during init: must be ignored (R3)
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!req && !busy && !init_done, "R1 flags low in reset", {req, busy, init_done}, 0);

    rst_ni = 1'b1;
    n = 0;
    quiet = 1'b1;
    for (int i = 0; i < PAUSE; i++) begin
      @(negedge clk);
      n++;
      if (!ras_n || !cas_n) quiet = 1'b0;
    end
    chk(quiet, "R2 no strobes during pause", int'(quiet), 1);
    @(negedge clk);
    n++;
    chk(cas_n == 1'b0, "R2 CAS falls right after pause", int'(cas_n), 0);
    while (!init_done) begin
      @(negedge clk);
      n++;
    end
    chk(n == PAUSE + NINIT * CYC, "R3 init done edge", n, PAUSE + NINIT * CYC);
    chk(ras_falls == NINIT, "R3 init refresh count", ras_falls, NINIT);

    // R11: grant without request does nothing
    n = 0;
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      n++;
      if (busy || !ras_n || req) quiet = 1'b0;
    end
    chk(quiet, "R11 grant ignored without request", int'(quiet), 1);
    grant = 1'b0;
    while (!req) begin
      @(negedge clk);
      n++;
    end
    chk(n == INTV, "R8 first request after interval", n, INTV);
    chk(init_done == 1'b1, "R3 init done stays high", int'(init_done), 1);

    // table: late grants
    for (int v = 0; v < N_VEC; v++) begin
      while (!req) @(negedge clk);
      repeat ((WAIT_TBL[v] - 1) * INTV + 2) @(negedge clk);
      chk(req && !busy, "R8 request pending", int'(req), 1);
      base = ras_falls;
      grant = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R10 busy after grant", int'(busy), 1);
      while (req || busy) @(negedge clk);
      chk(ras_falls - base == EXP_TBL[v], "R9 refreshes on drain", ras_falls - base, EXP_TBL[v]);
      grant = 1'b0;
    end

    // R1: reset during a refresh cycle
    while (!req) @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!ras_n, "R1 setup: RAS low mid-cycle", int'(ras_n), 0);
    rst_ni = 1'b0;
    grant = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !busy && !init_done, "R1 reset mid-cycle",
        {ras_n, cas_n, busy, init_done}, 12);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule